// File: doc/BRIEF.md
# Video Peripheral Bus Host Register Front End

This block is the CPU-facing register front end of a host that carries register accesses out to a serial video-peripheral bus with four channels. Software programs a cycle address, then accesses a data register, and each such access can start one bus cycle. The cycle is sent to the channel named in the cycle address. A busy flag in the control register stays high while the cycle is in flight. A cycle ends in one of two ways: the peripheral acknowledges it, or a programmable wait limit runs out.

On the peripheral side there is a plain request/acknowledge handshake. The request, direction, channel, target address, FIFO marker and write data are all latched when the cycle starts, and they stay steady until the cycle ends. The data returned by an acknowledged read cycle is captured, and software reads it later through the data register.

A read of the data register does two things. It returns the value captured earlier, and, if reads are enabled, it starts a new read cycle. Software therefore reads twice: once to launch the cycle, and once more, with reads disabled, to fetch the result. When no acknowledge arrives in time, the cycle ends and a sticky flag is set for the channel that was addressed. Software clears that flag by writing a one to it.

Top module: `vbus_host_regs`

## Requirements
- R1: After reset, the registers read as follows. Index 0 (cycle address) reads 0. Index 1 (data) reads 0. Index 2 (status) reads 0x100. Index 3 (control) reads 0x00F. No request is driven.
- R2: The cycle address holds the channel in bits 15:14, the read marker in bit 13, the FIFO marker in bit 12 and the target address in bits 11:0. During a cycle, these values appear on the channel, FIFO and target-address outputs as they were latched at launch.
- R3: A CPU write to the data register while the read marker is 0 starts a write cycle. From the next cycle, request is 1, the write strobe is 1 and the write data equals the written value. A data write while the read marker is 1 starts nothing.
- R4: Bit 13 of the control register reads 1 while a cycle runs. An acknowledge ends the cycle at the next edge. An acknowledge that arrives in the last allowed wait cycle still completes the cycle without a timeout.
- R5: Status bit 8 is the read-disable bit. When it is 0 and the read marker is 1, a CPU read of the data register returns the previously captured value and starts a read cycle (request 1, write strobe 0).
- R6: When status bit 8 is 1, a CPU read of the data register returns the captured value and starts no cycle.
- R7: When a read cycle is acknowledged, the peripheral read data is captured and returned by later data-register reads. A write cycle does not change the captured value.
- R8: The control register bits 3:0 hold the wait limit W. A cycle with no acknowledge keeps its request up for W+1 cycles and then ends. At that point busy clears, status flag bit [channel] (bits 3:0) is set, and the captured data is left unchanged.
- R9: Writing 1 to a status flag bit clears that flag. Writing 0 to it leaves it unchanged.
- R10: A cycle request that arrives while busy is ignored. The latched write data and address stay unchanged on the peripheral outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_sel | input | 1 | CPU register access strobe, one cycle per access |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 2 | Register index: 0 address, 1 data, 2 status, 3 control |
| cpu_wdata | input | DATA_W | CPU write data |
| cpu_rdata | output | DATA_W | CPU read data, valid in the access cycle |
| pb_req | output | 1 | Bus cycle request, high while busy |
| pb_we | output | 1 | 1 = write cycle, 0 = read cycle |
| pb_chan | output | 2 | Target channel |
| pb_addr | output | 12 | Target register address |
| pb_fifo | output | 1 | FIFO-style access marker |
| pb_wdata | output | DATA_W | Write data for the peripheral |
| pb_ack | input | 1 | Peripheral acknowledge |
| pb_rdata | input | DATA_W | Peripheral read data, valid with acknowledge |

## Verification
Several kinds of internal fault show at the ports. A wait counter that runs off by one shows up as a request pulse one cycle longer or shorter than W+1, and as a flag being set, or missing, after a boundary acknowledge; this is visible in the cycle where the request is expected to fall. If the cycle registers are latched again while busy, the write data or channel outputs change in the cycle after the second access. A wrong trigger gate either raises a request in the cycle after an access that should start nothing, or fails to raise one. Capture faults only appear at the next data read with reads disabled, which may be many cycles after the corrupting acknowledge or timeout.

// File: rtl/vbus_host_pkg.sv
package vbus_host_pkg;

  localparam int CH_N   = 4;
  localparam int CH_W   = $clog2(CH_N);
  localparam int TGT_W  = 12;

  localparam int ADDR_RD_BIT   = 13;
  localparam int CTRL_BUSY_BIT = 13;
  localparam int STAT_RDIS_BIT = 8;

  typedef enum logic [1:0] {
    IDX_ADDR = 2'd0,
    IDX_DATA = 2'd1,
    IDX_STAT = 2'd2,
    IDX_CTRL = 2'd3
  } reg_idx_e;

  // field order is decoded by software: channel 15:14, read 13, fifo 12
  typedef struct packed {
    logic [CH_W-1:0]  chan;
    logic             rd;
    logic             fifo;
    logic [TGT_W-1:0] tgt;
  } vaddr_t;

  localparam int VADDR_W = $bits(vaddr_t);

endpackage

// File: rtl/vbus_csr_bank.sv
module vbus_csr_bank
  import vbus_host_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int WAIT_W     = 4,
  parameter int RESET_WAIT = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_sel,
  input  logic              cpu_wr,
  input  logic [1:0]        cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              busy,
  input  logic [DATA_W-1:0] cap_data,
  input  logic              tmo_evt,
  input  logic [CH_W-1:0]   tmo_chan,
  output vaddr_t            addr_q,
  output logic [WAIT_W-1:0] wait_q,
  output logic              rdis_q,
  output logic [CH_N-1:0]   flags_q
);

  vaddr_t            addr_d;
  logic [WAIT_W-1:0] wait_d;
  logic              rdis_d;
  logic [CH_N-1:0]   flags_d;
  logic              wr_stb;
  logic              addr_en, wait_en, stat_en;

  assign wr_stb  = cpu_sel && cpu_wr;
  assign addr_en = wr_stb && (cpu_addr == IDX_ADDR);
  assign stat_en = wr_stb && (cpu_addr == IDX_STAT);
  assign wait_en = wr_stb && (cpu_addr == IDX_CTRL);

  always_comb begin
    addr_d  = addr_en ? vaddr_t'(cpu_wdata[VADDR_W-1:0]) : addr_q;
    wait_d  = wait_en ? cpu_wdata[WAIT_W-1:0] : wait_q;
    rdis_d  = stat_en ? cpu_wdata[STAT_RDIS_BIT] : rdis_q;
    flags_d = stat_en ? (flags_q & ~cpu_wdata[CH_N-1:0]) : flags_q;
    if (tmo_evt) flags_d[tmo_chan] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wait_q  <= WAIT_W'(RESET_WAIT);
      rdis_q  <= 1'b1;
      flags_q <= '0;
    end else begin
      addr_q  <= addr_d;
      wait_q  <= wait_d;
      rdis_q  <= rdis_d;
      flags_q <= flags_d;
    end
  end

  always_comb begin
    cpu_rdata = '0;
    unique case (cpu_addr)
      IDX_ADDR: cpu_rdata[VADDR_W-1:0] = addr_q;
      IDX_DATA: cpu_rdata = cap_data;
      IDX_STAT: begin
        cpu_rdata[CH_N-1:0]     = flags_q;
        cpu_rdata[STAT_RDIS_BIT] = rdis_q;
      end
      default: begin
        cpu_rdata[WAIT_W-1:0]    = wait_q;
        cpu_rdata[CTRL_BUSY_BIT] = busy;
      end
    endcase
  end

  // R8: the timed-out channel's flag is up one edge later
  assert_flag_on_timeout_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_evt |=> flags_q[$past(tmo_chan)]);

  for (genvar c = 0; c < CH_N; c++) begin : g_w1c
    // R9: a one written to a flag clears it unless a timeout sets it
    assert_w1c_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_en && cpu_wdata[c] && !(tmo_evt && tmo_chan == CH_W'(c))) |=> !flags_q[c]);
    // R9: a zero written leaves the flag as it was
    assert_w0_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_en && !cpu_wdata[c] && flags_q[c]) |=> flags_q[c]);
  end

endmodule

// File: rtl/vbus_cycle_engine.sv
module vbus_cycle_engine
  import vbus_host_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              launch_rd,
  input  vaddr_t            launch_addr,
  input  logic [DATA_W-1:0] launch_wdata,
  input  logic [WAIT_W-1:0] max_wait,
  input  logic              pb_ack,
  input  logic [DATA_W-1:0] pb_rdata,
  output logic              busy,
  output logic              pb_we,
  output vaddr_t            cyc_addr,
  output logic [DATA_W-1:0] pb_wdata,
  output logic [DATA_W-1:0] cap_data,
  output logic              tmo_evt
);

  logic              busy_q, busy_d;
  logic              we_q, we_d;
  vaddr_t            cyc_q, cyc_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic [DATA_W-1:0] cap_q, cap_d;
  logic [WAIT_W-1:0] lim_q, lim_d;
  logic [WAIT_W-1:0] cnt_q, cnt_d;
  logic              accept;

  assign accept  = launch && !busy_q;
  assign tmo_evt = busy_q && !pb_ack && (cnt_q == lim_q);

  always_comb begin
    busy_d  = busy_q;
    we_d    = we_q;
    cyc_d   = cyc_q;
    wdata_d = wdata_q;
    cap_d   = cap_q;
    lim_d   = lim_q;
    cnt_d   = cnt_q;
    if (accept) begin
      busy_d = 1'b1;
      we_d   = !launch_rd;
      cyc_d  = launch_addr;
      lim_d  = max_wait;
      cnt_d  = '0;
      if (!launch_rd) wdata_d = launch_wdata;
    end else if (busy_q) begin
      if (pb_ack) begin
        busy_d = 1'b0;
        if (!we_q) cap_d = pb_rdata;
      end else if (tmo_evt) begin
        busy_d = 1'b0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      we_q    <= 1'b0;
      cyc_q   <= '0;
      wdata_q <= '0;
      cap_q   <= '0;
      lim_q   <= '0;
      cnt_q   <= '0;
    end else begin
      busy_q  <= busy_d;
      we_q    <= we_d;
      cyc_q   <= cyc_d;
      wdata_q <= wdata_d;
      cap_q   <= cap_d;
      lim_q   <= lim_d;
      cnt_q   <= cnt_d;
    end
  end

  assign busy     = busy_q;
  assign pb_we    = we_q;
  assign cyc_addr = cyc_q;
  assign pb_wdata = wdata_q;
  assign cap_data = cap_q;

  // R4: an acknowledge ends the cycle at the next edge
  assert_ack_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && pb_ack) |=> !busy_q);
  // R7: acknowledged read captures the peripheral data
  assert_read_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && pb_ack && !we_q) |=> (cap_q == $past(pb_rdata)));
  // R8: timeout ends the cycle and keeps captured data
  assert_timeout_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_evt |=> (!busy_q && $stable(cap_q)));
  // R10: latched cycle fields hold while busy
  assert_busy_ignores_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> ($stable(cyc_q) && $stable(wdata_q)));

endmodule

// File: rtl/vbus_host_regs.sv
module vbus_host_regs
  import vbus_host_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int WAIT_W     = 4,
  parameter int RESET_WAIT = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_sel,
  input  logic              cpu_wr,
  input  logic [1:0]        cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              pb_req,
  output logic              pb_we,
  output logic [1:0]        pb_chan,
  output logic [11:0]       pb_addr,
  output logic              pb_fifo,
  output logic [DATA_W-1:0] pb_wdata,
  input  logic              pb_ack,
  input  logic [DATA_W-1:0] pb_rdata
);

  vaddr_t            addr_q;
  vaddr_t            cyc_addr;
  logic [WAIT_W-1:0] wait_q;
  logic              rdis_q;
  logic [CH_N-1:0]   flags_q;
  logic              busy;
  logic [DATA_W-1:0] cap_data;
  logic              tmo_evt;
  logic              rd_stb, wr_stb, launch;

  assign rd_stb = cpu_sel && !cpu_wr && (cpu_addr == IDX_DATA);
  assign wr_stb = cpu_sel &&  cpu_wr && (cpu_addr == IDX_DATA);
  assign launch = (wr_stb && !addr_q.rd) || (rd_stb && !rdis_q && addr_q.rd);

  vbus_csr_bank #(
    .DATA_W     (DATA_W),
    .WAIT_W     (WAIT_W),
    .RESET_WAIT (RESET_WAIT)
  ) i_csr (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_sel   (cpu_sel),
    .cpu_wr    (cpu_wr),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_rdata (cpu_rdata),
    .busy      (busy),
    .cap_data  (cap_data),
    .tmo_evt   (tmo_evt),
    .tmo_chan  (cyc_addr.chan),
    .addr_q    (addr_q),
    .wait_q    (wait_q),
    .rdis_q    (rdis_q),
    .flags_q   (flags_q)
  );

  vbus_cycle_engine #(
    .DATA_W (DATA_W),
    .WAIT_W (WAIT_W)
  ) i_engine (
    .clk          (clk),
    .rst_n        (rst_n),
    .launch       (launch),
    .launch_rd    (!cpu_wr),
    .launch_addr  (addr_q),
    .launch_wdata (cpu_wdata),
    .max_wait     (wait_q),
    .pb_ack       (pb_ack),
    .pb_rdata     (pb_rdata),
    .busy         (busy),
    .pb_we        (pb_we),
    .cyc_addr     (cyc_addr),
    .pb_wdata     (pb_wdata),
    .cap_data     (cap_data),
    .tmo_evt      (tmo_evt)
  );

  assign pb_req  = busy;
  assign pb_chan = cyc_addr.chan;
  assign pb_addr = cyc_addr.tgt;
  assign pb_fifo = cyc_addr.fifo;

  // R5: enabled data read with read marker starts a read cycle
  assert_read_launch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !rdis_q && addr_q.rd && !busy) |=> (pb_req && !pb_we));
  // R6: disabled data read starts nothing
  assert_read_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && rdis_q && !busy) |=> !pb_req);
  // R3: data write with read marker clear starts a write cycle
  assert_write_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !addr_q.rd && !busy) |=> (pb_req && pb_we && pb_wdata == $past(cpu_wdata)));

endmodule

// File: tb/test_vbus_host_regs.sv
module test_vbus_host_regs;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cpu_sel, cpu_wr;
  logic [1:0]    cpu_addr;
  logic [DW-1:0] cpu_wdata, cpu_rdata;
  logic          pb_req, pb_we, pb_fifo, pb_ack;
  logic [1:0]    pb_chan;
  logic [11:0]   pb_addr;
  logic [DW-1:0] pb_wdata, pb_rdata;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  string         tag_q[$];
  logic [DW-1:0] val_q[$];
  logic [DW-1:0] obs_data;
  bit            obs_valid = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vbus_host_regs i_vbus_host_regs (
    .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .pb_req(pb_req), .pb_we(pb_we), .pb_chan(pb_chan), .pb_addr(pb_addr),
    .pb_fifo(pb_fifo), .pb_wdata(pb_wdata), .pb_ack(pb_ack), .pb_rdata(pb_rdata)
  );

  // scoreboard monitor: pops the expected item and compares
  initial begin
    forever begin
      wait (obs_valid);
      begin
        string         t;
        logic [DW-1:0] e;
        t = tag_q.pop_front();
        e = val_q.pop_front();
        checks++;
        if (obs_data !== e) begin
          errors++;
          $display("FAIL %s: actual 0x%08h expected 0x%08h", t, obs_data, e);
        end
      end
      obs_valid = 0;
    end
  end

  task automatic observe(input string t, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    tag_q.push_back(t);
    val_q.push_back(exp);
    obs_data  = act;
    obs_valid = 1;
    wait (!obs_valid);
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    cpu_sel = 1; cpu_wr = 1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_sel = 0; cpu_wr = 0;
  endtask

  task automatic reg_read(input logic [1:0] a, input string t, input logic [DW-1:0] exp);
    @(negedge clk);
    cpu_sel = 1; cpu_wr = 0; cpu_addr = a;
    #1;
    observe(t, cpu_rdata, exp);
    @(negedge clk);
    cpu_sel = 0;
  endtask

  task automatic ack_once(input logic [DW-1:0] d);
    @(negedge clk);
    pb_ack = 1; pb_rdata = d;
    @(negedge clk);
    pb_ack = 0; pb_rdata = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    rst_n = 0; cpu_sel = 0; cpu_wr = 0; cpu_addr = 0; cpu_wdata = 0;
    pb_ack = 0; pb_rdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    reg_read(2'd0, "R1 addr reset", 32'h0);
    reg_read(2'd2, "R1 status reset", 32'h100);
    reg_read(2'd3, "R1 control reset", 32'h00F);
    reg_read(2'd1, "R1 data reset", 32'h0);
    observe("R1 no request", pb_req, 0);

    // R2 R3 write cycle, channel 2, FIFO, target 0x0A5
    reg_write(2'd0, 32'h90A5);
    reg_write(2'd1, 32'h12345678);
    observe("R3 req", pb_req, 1);
    observe("R3 we", pb_we, 1);
    observe("R3 wdata", pb_wdata, 32'h12345678);
    observe("R2 chan", pb_chan, 2);
    observe("R2 addr", pb_addr, 12'h0A5);
    observe("R2 fifo", pb_fifo, 1);
    reg_read(2'd3, "R4 busy bit", 32'h200F);
    // R10 data write while busy is ignored
    reg_write(2'd0, 32'h4011);
    reg_write(2'd1, 32'hDEAD0000);
    observe("R10 wdata held", pb_wdata, 32'h12345678);
    observe("R10 chan held", pb_chan, 2);
    ack_once(32'hFFFF0000);
    observe("R4 ack ends", pb_req, 0);
    reg_read(2'd3, "R4 not busy", 32'h00F);
    reg_read(2'd1, "R7 write no capture", 32'h0);

    // R3 write with read marker set is ignored (channel 1, target 0x010)
    reg_write(2'd0, 32'h6010);
    reg_write(2'd1, 32'h55);
    observe("R3 ignored write", pb_req, 0);

    // R6 disabled read starts nothing
    reg_read(2'd1, "R6 data disabled", 32'h0);
    observe("R6 no cycle", pb_req, 0);

    // R5 R7 read cycle
    reg_write(2'd2, 32'h000);
    reg_read(2'd1, "R5 stale data", 32'h0);
    observe("R5 req", pb_req, 1);
    observe("R5 read dir", pb_we, 0);
    observe("R2 read chan", pb_chan, 1);
    observe("R2 read addr", pb_addr, 12'h010);
    ack_once(32'hCAFEF00D);
    reg_write(2'd2, 32'h100);
    reg_read(2'd1, "R7 captured", 32'hCAFEF00D);
    observe("R6 no cycle after capture", pb_req, 0);

    // R8 timeout with wait limit 15: request lasts 16 cycles
    reg_write(2'd0, 32'h8033);
    reg_write(2'd1, 32'h1);
    n = 0;
    for (int i = 0; i < 40; i++) begin
      if (!pb_req) break;
      n++;
      @(negedge clk);
    end
    observe("R8 request length 16", n, 16);
    reg_read(2'd2, "R8 flag chan2", 32'h104);
    reg_read(2'd3, "R8 busy cleared", 32'h00F);

    // R4 boundary: wait limit 3, ack in the 4th cycle completes
    reg_write(2'd3, 32'h3);
    reg_write(2'd0, 32'h4000);
    reg_write(2'd1, 32'h2);
    repeat (3) @(negedge clk);
    pb_ack = 1;
    @(negedge clk);
    pb_ack = 0;
    observe("R4 boundary ack ends", pb_req, 0);
    reg_read(2'd2, "R4 boundary no flag", 32'h104);

    // R8 read timeout on channel 1 keeps captured data
    reg_write(2'd2, 32'h000);
    reg_write(2'd0, 32'h6000);
    reg_read(2'd1, "R5 stale before timeout", 32'hCAFEF00D);
    repeat (6) @(negedge clk);
    observe("R8 read timed out", pb_req, 0);
    reg_write(2'd2, 32'h100);
    reg_read(2'd2, "R8 flag chan1", 32'h106);
    reg_read(2'd1, "R8 data kept", 32'hCAFEF00D);

    // R9 write-one-to-clear
    reg_write(2'd2, 32'h104);
    reg_read(2'd2, "R9 clear chan2 only", 32'h102);
    reg_write(2'd2, 32'h100);
    reg_read(2'd2, "R9 zero keeps", 32'h102);
    reg_write(2'd2, 32'h10F);
    reg_read(2'd2, "R9 clear all", 32'h100);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule